// File: doc/BRIEF.md
# Character LCD Bus Access Controller

This block turns single host requests into timed accesses on the parallel bus of a character LCD module. The bus has a 16-bit data path (separate input, output and output-enable), a register-select line, a read/write line and an enable strobe. Every access has three phases: address setup, enable strobe and hold. Each phase length is a cycle count taken from configuration inputs. Reads and writes have separate sets of counts. A programmable idle gap follows every access before the next one may begin.

The request side is a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the access and its gap are finished. A request held during that time is stalled and has no effect. The requester must hold a stalled request and must not change it. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and `rsp_rdata` holds the data of the most recent read. The configuration inputs are sampled only on the accepting edge.

Top module: `lcd_char_bus_ctrl`

## Requirements
In these requirements, edge 0 is the clock edge that accepts a request. S is the setup count. T is the strobe count and H is the hold count, each taken as 1 when programmed 0. G is the gap count. "After edge n" means the value that is visible during the cycle following edge n.
- R1: Synchronous reset `rst` (active high) leaves `req_ready`=1, `rsp_valid`=0, `bus_en`=0, `bus_doe`=0, `bus_rnw`=1, `bus_rs`=0 and `bus_dout`=0.
- R2: For a write, `bus_en` is 1 after edges S through S+T-1 and 0 otherwise. S, T and H come from `cfg_wr_setup` (0..31), `cfg_wr_strobe` (1..63) and `cfg_wr_hold` (1..15).
- R3: A read uses `cfg_rd_setup`, `cfg_rd_strobe` and `cfg_rd_hold` in place of the write counts, with the same ranges and the same timing as R2. The write counts have no influence on a read, and the read counts have no influence on a write.
- R4: A setup count of 0 raises `bus_en` right after edge 0. A strobe count or hold count of 0 behaves as 1.
- R5: During a write, after edges 0 through S+T+H-1, `bus_doe`=1 and `bus_dout` equals the accepted `req_wdata`. Also `bus_rnw`=0 and `bus_rs` equals the accepted `req_rs`. None of these change while the access runs.
- R6: During a read, after edges 0 through S+T+H-1, `bus_doe`=0, `bus_rnw`=1 and `bus_rs` equals the accepted `req_rs`. `bus_din` is sampled on edge S+T, the last strobe edge. That value appears on `rsp_rdata`, and later `bus_din` changes do not alter it.
- R7: `rsp_valid` is 1 only after edge S+T+H, for one cycle. A write leaves `rsp_rdata` unchanged.
- R8: `req_ready` is 0 after edges 0 through S+T+H+G-1 and 1 after edge S+T+H+G, with G from `cfg_cs_gap` (0..3). A request offered while `req_ready`=0 causes no bus activity.
- R9: Changes to any configuration input after edge 0 do not alter the running access.
- R10: After edge S+T+H, the bus returns to idle: `bus_en`=0, `bus_doe`=0, `bus_rnw`=1, `bus_rs`=0 and `bus_dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rs | input | 1 | Register-select value for the access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | 16 | Data captured by the latest read |
| cfg_wr_setup | input | 5 | Write setup cycles |
| cfg_wr_strobe | input | 6 | Write strobe cycles |
| cfg_wr_hold | input | 4 | Write hold cycles |
| cfg_rd_setup | input | 5 | Read setup cycles |
| cfg_rd_strobe | input | 6 | Read strobe cycles |
| cfg_rd_hold | input | 4 | Read hold cycles |
| cfg_cs_gap | input | 2 | Idle cycles between accesses |
| bus_din | input | 16 | Data bus input from the display |
| bus_dout | output | 16 | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| bus_rs | output | 1 | Register-select line |
| bus_rnw | output | 1 | Read/write line, 1 = read |
| bus_en | output | 1 | Enable strobe |

## Verification
The bench builds the block with its default widths: 5-bit setup, 6-bit strobe, 4-bit hold and 2-bit gap counts. Within those widths it sweeps setup, strobe, hold and gap over 0 to 3 for both reads and writes. This reaches every zero-count shortcut and every gap length, and every phase boundary is checked cycle by cycle against arithmetic edge numbers. Two more accesses use the largest legal counts, so the full width of the shared counter is exercised. In every access the bench offers a stalled request, changes all configuration inputs after acceptance, and drives `bus_din` with a value that changes each cycle, so the sampling edge is identified exactly.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } phase_e;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_timing_select.sv
module lcd_timing_select #(
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned GAP_W    = 2,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                is_write,
  input  logic [SETUP_W-1:0]  wr_setup,
  input  logic [STROBE_W-1:0] wr_strobe,
  input  logic [HOLD_W-1:0]   wr_hold,
  input  logic [SETUP_W-1:0]  rd_setup,
  input  logic [STROBE_W-1:0] rd_strobe,
  input  logic [HOLD_W-1:0]   rd_hold,
  input  logic [GAP_W-1:0]    gap_in,
  output logic [CNT_W-1:0]    now_setup,
  output logic [CNT_W-1:0]    now_strobe,
  output logic [CNT_W-1:0]    lat_strobe,
  output logic [CNT_W-1:0]    lat_hold,
  output logic [CNT_W-1:0]    lat_gap
);

  logic [SETUP_W-1:0]  s_pick;
  logic [STROBE_W-1:0] t_pick;
  logic [HOLD_W-1:0]   h_pick;
  logic [CNT_W-1:0]    hold_cl;

  // Pick the count set for the access direction; zero strobe/hold behave as one
  always_comb begin
    s_pick     = is_write ? wr_setup  : rd_setup;
    t_pick     = is_write ? wr_strobe : rd_strobe;
    h_pick     = is_write ? wr_hold   : rd_hold;
    now_setup  = CNT_W'(s_pick);
    now_strobe = (t_pick == '0) ? CNT_W'(1) : CNT_W'(t_pick);
    hold_cl    = (h_pick == '0) ? CNT_W'(1) : CNT_W'(h_pick);
  end

  // Snapshot at acceptance so later configuration changes cannot disturb the access
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_strobe <= CNT_W'(1);
      lat_hold   <= CNT_W'(1);
      lat_gap    <= '0;
    end else if (load) begin
      lat_strobe <= now_strobe;
      lat_hold   <= hold_cl;
      lat_gap    <= CNT_W'(gap_in);
    end
  end

endmodule

// File: rtl/lcd_bus_sequencer.sv
module lcd_bus_sequencer
  import lcd_bus_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [CNT_W-1:0] now_setup,
  input  logic [CNT_W-1:0] now_strobe,
  input  logic [CNT_W-1:0] lat_strobe,
  input  logic [CNT_W-1:0] lat_hold,
  input  logic [CNT_W-1:0] lat_gap,
  output phase_e           phase_d,
  output logic             capture,
  output logic             hold_end
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last     = (cnt_q == '0);
  assign capture  = (phase_q == PH_STROBE) && last;
  assign hold_end = (phase_q == PH_HOLD) && last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? cnt_q : cnt_q - CNT_W'(1);
    case (phase_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (accept) begin
          if (now_setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = now_setup - CNT_W'(1);
          end else begin
            phase_d = PH_STROBE;
            cnt_d   = now_strobe - CNT_W'(1);
          end
        end
      end
      PH_SETUP: if (last) begin
        phase_d = PH_STROBE;
        cnt_d   = lat_strobe - CNT_W'(1);
      end
      PH_STROBE: if (last) begin
        phase_d = PH_HOLD;
        cnt_d   = lat_hold - CNT_W'(1);
      end
      PH_HOLD: if (last) begin
        if (lat_gap != '0) begin
          phase_d = PH_GAP;
          cnt_d   = lat_gap - CNT_W'(1);
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_GAP: if (last) phase_d = PH_IDLE;
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/lcd_bus_pins.sv
module lcd_bus_pins
  import lcd_bus_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          req_write,
  input  logic          req_rs,
  input  logic [DW-1:0] req_wdata,
  input  phase_e        phase_d,
  input  logic          capture,
  input  logic          hold_end,
  input  logic [DW-1:0] bus_din,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          bus_rs,
  output logic          bus_rnw,
  output logic          bus_en
);

  logic active_d;

  assign active_d = phase_d inside {PH_SETUP, PH_STROBE, PH_HOLD};

  // Every pin is a flop fed from the next phase, so pins change with the phase
  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      done     <= 1'b0;
      rdata    <= '0;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
      bus_rs   <= 1'b0;
      bus_rnw  <= 1'b1;
      bus_en   <= 1'b0;
    end else begin
      ready  <= (phase_d == PH_IDLE);
      done   <= hold_end;
      bus_en <= (phase_d == PH_STROBE);
      if (accept) begin
        bus_rs   <= req_rs;
        bus_rnw  <= ~req_write;
        bus_doe  <= req_write;
        bus_dout <= req_write ? req_wdata : '0;
      end else if (!active_d) begin
        bus_rs   <= 1'b0;
        bus_rnw  <= 1'b1;
        bus_doe  <= 1'b0;
        bus_dout <= '0;
      end
      if (capture && bus_rnw) rdata <= bus_din;
    end
  end

endmodule

// File: rtl/lcd_char_bus_ctrl.sv
module lcd_char_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned GAP_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_rs,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  input  logic [SETUP_W-1:0]  cfg_wr_setup,
  input  logic [STROBE_W-1:0] cfg_wr_strobe,
  input  logic [HOLD_W-1:0]   cfg_wr_hold,
  input  logic [SETUP_W-1:0]  cfg_rd_setup,
  input  logic [STROBE_W-1:0] cfg_rd_strobe,
  input  logic [HOLD_W-1:0]   cfg_rd_hold,
  input  logic [GAP_W-1:0]    cfg_cs_gap,
  input  logic [DW-1:0]       bus_din,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_doe,
  output logic                bus_rs,
  output logic                bus_rnw,
  output logic                bus_en
);

  localparam int unsigned CNT_W = wider(wider(SETUP_W, STROBE_W), wider(HOLD_W, GAP_W));

  logic             accept;
  logic [CNT_W-1:0] now_setup, now_strobe, lat_strobe, lat_hold, lat_gap;
  phase_e           phase_d;
  logic             capture, hold_end;

  assign accept = req_valid && req_ready;

  lcd_timing_select #(
    .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W),
    .GAP_W(GAP_W), .CNT_W(CNT_W)
  ) u_tsel (
    .clk(clk), .rst(rst), .load(accept), .is_write(req_write),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .gap_in(cfg_cs_gap), .now_setup(now_setup), .now_strobe(now_strobe),
    .lat_strobe(lat_strobe), .lat_hold(lat_hold), .lat_gap(lat_gap)
  );

  lcd_bus_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept),
    .now_setup(now_setup), .now_strobe(now_strobe),
    .lat_strobe(lat_strobe), .lat_hold(lat_hold), .lat_gap(lat_gap),
    .phase_d(phase_d), .capture(capture), .hold_end(hold_end)
  );

  lcd_bus_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .req_write(req_write),
    .req_rs(req_rs), .req_wdata(req_wdata), .phase_d(phase_d),
    .capture(capture), .hold_end(hold_end), .bus_din(bus_din),
    .ready(req_ready), .done(rsp_valid), .rdata(rsp_rdata),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rs(bus_rs),
    .bus_rnw(bus_rnw), .bus_en(bus_en)
  );

endmodule

// File: rtl/lcd_char_bus_ctrl_chk.sv
module lcd_char_bus_ctrl_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] bus_dout,
  input logic          bus_doe,
  input logic          bus_rs,
  input logic          bus_rnw,
  input logic          bus_en
);

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && $past(bus_en)) |-> ($stable(bus_rs) && $stable(bus_rnw) && $stable(bus_dout)));

  // R6
  read_released_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rnw |-> !bus_doe);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  busy_during_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> !req_ready);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_en && !bus_doe));

  // R2
  strobe_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!bus_en && !bus_doe));

endmodule

bind lcd_char_bus_ctrl lcd_char_bus_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rs(bus_rs),
  .bus_rnw(bus_rnw), .bus_en(bus_en)
);

// File: tb/lcd_char_bus_ctrl_tb.sv
module lcd_char_bus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_rs;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [4:0]  cfg_wr_setup, cfg_rd_setup;
  logic [5:0]  cfg_wr_strobe, cfg_rd_strobe;
  logic [3:0]  cfg_wr_hold, cfg_rd_hold;
  logic [1:0]  cfg_cs_gap;
  logic [15:0] bus_din, bus_dout;
  logic        bus_doe, bus_rs, bus_rnw, bus_en;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] last_rd = 16'h0000;

  always #10 clk = ~clk;

  lcd_char_bus_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_rs(req_rs), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_cs_gap(cfg_cs_gap), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_rs(bus_rs), .bus_rnw(bus_rnw), .bus_en(bus_en)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] din_at(input logic [15:0] seed, input int i);
    return seed ^ 16'((i + 1) * 16'h1357);
  endfunction

  // One access; edge 0 accepts it; checks sampled on the falling edge after each edge i
  task automatic access(input bit w, input bit rs, input logic [15:0] d,
                        input int s, input int t, input int h, input int g);
    int tt, hh, end_i, last;
    bit act, en_exp;
    string ttag;
    tt    = (t == 0) ? 1 : t;
    hh    = (h == 0) ? 1 : h;
    end_i = s + tt + hh;
    last  = end_i + g;
    ttag  = w ? "R2" : "R3";
    if (s == 0 || t == 0 || h == 0) ttag = {ttag, " R4"};
    if (w) begin
      cfg_wr_setup = 5'(s); cfg_wr_strobe = 6'(t); cfg_wr_hold = 4'(h);
      cfg_rd_setup = 5'(s + 9); cfg_rd_strobe = 6'(t + 5); cfg_rd_hold = 4'(h + 3);
    end else begin
      cfg_rd_setup = 5'(s); cfg_rd_strobe = 6'(t); cfg_rd_hold = 4'(h);
      cfg_wr_setup = 5'(s + 9); cfg_wr_strobe = 6'(t + 5); cfg_wr_hold = 4'(h + 3);
    end
    cfg_cs_gap = 2'(g);
    req_valid = 1'b1; req_write = w; req_rs = rs; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i <= last; i++) begin
      act    = (i < end_i);
      en_exp = (i >= s) && (i < s + tt);
      chk({ttag, " R9"}, "bus_en", 32'(bus_en), 32'(en_exp));
      chk(act ? (w ? "R5" : "R6") : "R10", "bus_doe", 32'(bus_doe), 32'(act && w));
      chk(act ? (w ? "R5" : "R6") : "R10", "bus_rnw", 32'(bus_rnw), 32'(act ? !w : 1'b1));
      chk(act ? (w ? "R5" : "R6") : "R10", "bus_rs", 32'(bus_rs), 32'(act ? rs : 1'b0));
      chk(act ? "R5" : "R10", "bus_dout", 32'(bus_dout), 32'((act && w) ? d : 16'h0));
      chk("R7", "rsp_valid", 32'(rsp_valid), 32'(i == end_i));
      chk("R8", "req_ready", 32'(req_ready), 32'(i >= last));
      if (i == end_i) begin
        if (!w) last_rd = din_at(d, s + tt - 1);
        chk(w ? "R7" : "R6", "rsp_rdata", 32'(rsp_rdata), 32'(last_rd));
      end
      // stalled request, scrambled configuration, moving read data
      req_valid = (i < last);
      req_write = ~w; req_rs = ~rs; req_wdata = ~d;
      cfg_wr_setup = 5'(i * 3 + 1); cfg_wr_strobe = 6'(i + 2); cfg_wr_hold = 4'(i + 5);
      cfg_rd_setup = 5'(i * 5 + 2); cfg_rd_strobe = 6'(i + 7); cfg_rd_hold = 4'(i + 1);
      cfg_cs_gap = 2'(i + 1);
      bus_din = din_at(d, i);
      if (i < last) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_rs = 1'b0; req_wdata = '0;
    cfg_wr_setup = '0; cfg_wr_strobe = '0; cfg_wr_hold = '0;
    cfg_rd_setup = '0; cfg_rd_strobe = '0; cfg_rd_hold = '0;
    cfg_cs_gap = '0; bus_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 32'(1));
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'(0));
    chk("R1", "bus_en", 32'(bus_en), 32'(0));
    chk("R1", "bus_doe", 32'(bus_doe), 32'(0));
    chk("R1", "bus_rnw", 32'(bus_rnw), 32'(1));
    chk("R1", "bus_rs", 32'(bus_rs), 32'(0));
    chk("R1", "bus_dout", 32'(bus_dout), 32'(0));
    rst = 1'b0;
    @(negedge clk);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int h = 0; h < 4; h++)
            for (int g = 0; g < 4; g++)
              access(w[0], s[0] ^ t[0], 16'(16'hA5C3 + s * 64 + t * 16 + h * 4 + g),
                     s, t, h, g);
    access(1'b1, 1'b1, 16'hBEEF, 31, 63, 15, 3);
    access(1'b0, 1'b0, 16'h3C5A, 31, 63, 15, 3);
    access(1'b1, 1'b0, 16'h0F0F, 0, 63, 15, 0);
    access(1'b0, 1'b1, 16'h7E81, 31, 1, 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule